// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in/first-out queue whose write side and read side run on unrelated clocks. Words are 9 bits wide by default, and the depth is a power of two set by a parameter (64 by default). Each pointer crosses into the other clock domain as a Gray code through a two-stage synchroniser. The pointers carry one extra bit, so a full queue and an empty queue can be told apart.

There are four status outputs, all active low. Full and almost-full are produced on the write clock. Empty and almost-empty are produced on the read clock. The almost thresholds come from two offset inputs, which a neighbouring offset register block supplies.

A write needs two write-side controls. The level of the second control while reset is held selects one of two modes. In single-enable mode the block also raises a load strobe for the offset register block. Reads need both read enables active at the same time. Read data is registered. An output enable can float the data bus and has no other effect.

Top module: `dual_clock_level_fifo`

## Requirements
- R1: While `rst_n` is low, both pointers clear, `full_n` and `afull_n` are 1, `empty_n` and `aempty_n` are 0, and the registered read data is 0.
- R2: The level of `wr_en2_ld` on write-clock edges while `rst_n` is low selects the mode. A 0 selects single-enable mode, in which `cfg_load` is 1 whenever `wr_en1_n` and `wr_en2_ld` are both 0. A 1 selects dual-enable mode, in which `cfg_load` is always 0.
- R3: A word is stored on a rising `wr_clk` edge only when `wr_en1_n`=0 and `wr_en2_ld`=1. Every other combination stores nothing, in either mode.
- R4: While `full_n` is 0, write requests are discarded and the stored words are unchanged.
- R5: A read happens on a rising `rd_clk` edge only when `rd_en1_n` and `rd_en2_n` are both 0 and `empty_n` is 1. Each read advances the read pointer by one.
- R6: With n words stored and almost-empty offset y, `empty_n` is 0 exactly when n=0, and `aempty_n` is 0 exactly when n<=y, once the read side has seen the last write.
- R7: With depth D and almost-full offset x, `full_n` is 0 exactly when n=D, and `afull_n` is 0 exactly when n>=D-x, once the write side has seen the last read.
- R8: When `oe_n` is 1, every bit of `rd_data` is high-impedance. When `oe_n` is 0, `rd_data` shows the output register. `oe_n` never moves either pointer.
- R9: Read data comes from a register. It shows the word read after the read edge, holds between reads, and words leave in the order they were written.
- R10: A word written into an empty queue raises `empty_n` two to four read-clock edges after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en1_n | input | 1 | First write enable, active low |
| wr_en2_ld | input | 1 | Second write enable (active high); its level during reset selects the mode |
| wr_data | input | WIDTH | Write data |
| afull_ofs | input | log2(DEPTH) | Almost-full offset x |
| aempty_ofs | input | log2(DEPTH) | Almost-empty offset y |
| full_n | output | 1 | Full flag, active low, write clock |
| afull_n | output | 1 | Almost-full flag, active low, write clock |
| cfg_load | output | 1 | Offset load strobe in single-enable mode |
| rd_clk | input | 1 | Read clock |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | WIDTH | Tri-state read data |
| empty_n | output | 1 | Empty flag, active low, read clock |
| aempty_n | output | 1 | Almost-empty flag, active low, read clock |

## Verification
The assertions assume three things about the inputs:
- every write-side input changes only with respect to `wr_clk`, and every read-side input only with respect to `rd_clk`;
- both offsets are below the depth;
- the offsets stay steady while flags are being judged.

The stimulus respects these limits. It drives each control on the falling edge of its own clock. It changes the offsets only while reset is held. Before comparing flags against the arithmetic model of the word count, it leaves several edges of both clocks for the synchronisers to settle.

// File: rtl/dual_clock_level_fifo.sv
module dual_clock_level_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9
) (
  input  logic                       wr_clk,
  input  logic                       rst_n,
  input  logic                       wr_en1_n,
  input  logic                       wr_en2_ld,
  input  logic [WIDTH-1:0]           wr_data,
  input  logic [$clog2(DEPTH)-1:0]   afull_ofs,
  input  logic [$clog2(DEPTH)-1:0]   aempty_ofs,
  output logic                       full_n,
  output logic                       afull_n,
  output logic                       cfg_load,
  input  logic                       rd_clk,
  input  logic                       rd_en1_n,
  input  logic                       rd_en2_n,
  input  logic                       oe_n,
  output logic [WIDTH-1:0]           rd_data,
  output logic                       empty_n,
  output logic                       aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];
  logic             mode_dual;
  logic             wr_fire, rd_fire;
  logic [PW-1:0]    wbin, wgray, rg_s1, rg_s2, wbin_nx, rbin_w, wcnt_nx;
  logic [PW-1:0]    rbin, rgray, wg_s1, wg_s2, rbin_nx, wbin_r, rcnt_nx;
  logic [WIDTH-1:0] q_reg;

  always_ff @(posedge wr_clk)
    if (!rst_n) mode_dual <= wr_en2_ld;

  assign cfg_load = !mode_dual && !wr_en1_n && !wr_en2_ld;
  assign wr_fire  = !wr_en1_n && wr_en2_ld && full_n;
  assign wbin_nx  = wbin + PW'(wr_fire);
  assign rbin_w   = gray2bin(rg_s2);
  assign wcnt_nx  = wbin_nx - rbin_w;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      rg_s1   <= '0;
      rg_s2   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= wbin_nx ^ (wbin_nx >> 1);
      rg_s1   <= rgray;
      rg_s2   <= rg_s1;
      full_n  <= (wcnt_nx != DEPTH_P);
      afull_n <= (wcnt_nx < (DEPTH_P - {1'b0, afull_ofs}));
    end
  end

  always_ff @(posedge wr_clk)
    if (wr_fire) mem[wbin[AW-1:0]] <= wr_data;

  assign rd_fire = !rd_en1_n && !rd_en2_n && empty_n;
  assign rbin_nx = rbin + PW'(rd_fire);
  assign wbin_r  = gray2bin(wg_s2);
  assign rcnt_nx = wbin_r - rbin_nx;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      wg_s1    <= '0;
      wg_s2    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
      q_reg    <= '0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rbin_nx ^ (rbin_nx >> 1);
      wg_s1    <= wgray;
      wg_s2    <= wg_s1;
      empty_n  <= (rcnt_nx != '0);
      aempty_n <= (rcnt_nx > {1'b0, aempty_ofs});
      if (rd_fire) q_reg <= mem[rbin[AW-1:0]];
    end
  end

  assign rd_data = oe_n ? {WIDTH{1'bz}} : q_reg;
endmodule

module dual_clock_level_fifo_chk #(
  parameter int PW = 7,
  parameter int WIDTH = 9
) (
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             rst_n,
  input logic             full_n,
  input logic             afull_n,
  input logic             empty_n,
  input logic             aempty_n,
  input logic [PW-1:0]    wbin,
  input logic [PW-1:0]    rbin,
  input logic [PW-1:0]    wgray,
  input logic [PW-1:0]    rgray,
  input logic             rd_fire,
  input logic [WIDTH-1:0] q_reg
);
  // R7
  full_implies_afull_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !afull_n);
  // R6
  empty_implies_aempty_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
  // R4
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |=> $stable(wbin));
  // R5
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |=> $stable(rbin));
  // R4
  wgray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)));
  // R5
  rgray_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $onehot0(rgray ^ $past(rgray)));
  // R9
  dout_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_fire |=> $stable(q_reg));
endmodule

bind dual_clock_level_fifo dual_clock_level_fifo_chk #(.PW(PW), .WIDTH(WIDTH)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
  .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
  .wbin(wbin), .rbin(rbin), .wgray(wgray), .rgray(rgray),
  .rd_fire(rd_fire), .q_reg(q_reg)
);

// File: tb/sim_dual_clock_level_fifo.sv
module sim_dual_clock_level_fifo;
  localparam int D  = 16;
  localparam int W  = 9;
  localparam int AW = $clog2(D);

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic wr_en1_n = 1, wr_en2_ld = 1, rd_en1_n = 1, rd_en2_n = 1, oe_n = 0;
  logic [W-1:0]  wr_data = '0;
  logic [AW-1:0] afull_ofs = '0, aempty_ofs = '0;
  logic full_n, afull_n, cfg_load, empty_n, aempty_n;
  wire  [W-1:0] qbus;
  int total = 0, bad = 0;

  for (genvar i = 0; i < W; i++) begin : g_pu
    pullup (qbus[i]);
  end

  always #10 wr_clk = ~wr_clk;
  always #13 rd_clk = ~rd_clk;

  dual_clock_level_fifo #(.DEPTH(D), .WIDTH(W)) u0 (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld),
    .wr_data(wr_data), .afull_ofs(afull_ofs), .aempty_ofs(aempty_ofs),
    .full_n(full_n), .afull_n(afull_n), .cfg_load(cfg_load),
    .rd_clk(rd_clk), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .oe_n(oe_n),
    .rd_data(qbus), .empty_n(empty_n), .aempty_n(aempty_n));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge rd_clk);
    repeat (5) @(negedge wr_clk);
    #1;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge wr_clk);
    rst_n = 0; wr_en2_ld = mode; wr_en1_n = 1;
    rd_en1_n = 1; rd_en2_n = 1;
    repeat (3) @(negedge wr_clk);
    rst_n = 1; wr_en2_ld = 1;
    settle();
  endtask

  task automatic push(input logic [W-1:0] d);
    @(negedge wr_clk);
    wr_data = d; wr_en1_n = 0; wr_en2_ld = 1;
    @(negedge wr_clk);
    wr_en1_n = 1;
  endtask

  task automatic pop();
    @(negedge rd_clk);
    rd_en1_n = 0; rd_en2_n = 0;
    @(negedge rd_clk);
    rd_en1_n = 1; rd_en2_n = 1;
    #1;
  endtask

  task automatic chk_flags(input string tag, input int n, input int x, input int y);
    chk({tag, " R7 full_n"},   full_n,   int'(n != D));
    chk({tag, " R7 afull_n"},  afull_n,  int'(n < D - x));
    chk({tag, " R6 empty_n"},  empty_n,  int'(n != 0));
    chk({tag, " R6 aempty_n"}, aempty_n, int'(n > y));
  endtask

  function automatic logic [W-1:0] pat(input int p, input int i);
    return W'((p * 37 + i * 11 + 5) & 9'h1FF);
  endfunction

  initial begin
    int xs[4] = '{0, 3, 7, 15};
    int ys[4] = '{0, 5, 7, 15};
    do_reset(1'b1);
    // R1 reset state
    chk("R1 full_n", full_n, 1);
    chk("R1 afull_n", afull_n, 1);
    chk("R1 empty_n", empty_n, 0);
    chk("R1 aempty_n", aempty_n, 0);
    chk("R1 data", int'(qbus), 0);
    // R8 high impedance
    oe_n = 1; #1;
    chk("R8 float", int'(qbus), 9'h1FF);
    oe_n = 0; #1;

    // R2 dual mode: no load strobe
    @(negedge wr_clk); wr_en1_n = 0; wr_en2_ld = 0; #1;
    chk("R2 dual cfg_load", cfg_load, 0);
    @(negedge wr_clk); wr_en1_n = 1; wr_en2_ld = 1;
    settle();
    chk("R3 en2 low no write", empty_n, 0);
    @(negedge wr_clk); wr_en1_n = 1; wr_en2_ld = 1; wr_data = 9'h055;
    repeat (3) @(negedge wr_clk);
    settle();
    chk("R3 en1 high no write", empty_n, 0);

    // R2 single mode
    do_reset(1'b0);
    @(negedge wr_clk); wr_en1_n = 0; wr_en2_ld = 0; #1;
    chk("R2 single cfg_load", cfg_load, 1);
    @(negedge wr_clk); wr_en1_n = 1; wr_en2_ld = 1; #1;
    chk("R2 single idle cfg_load", cfg_load, 0);
    settle();
    chk("R3 load no write", empty_n, 0);

    // R10 first word latency
    begin
      int edges = 0;
      push(9'h0A5);
      while (!empty_n && edges < 10) begin
        @(posedge rd_clk); #1; edges++;
      end
      total++;
      if (edges < 2 || edges > 4) begin
        bad++;
        $display("FAIL R10 act=%0d exp=2..4", edges);
      end
    end
    settle();
    // R5 single enable does not read
    @(negedge rd_clk); rd_en1_n = 0; rd_en2_n = 1;
    @(negedge rd_clk); rd_en1_n = 1; rd_en2_n = 0;
    @(negedge rd_clk); rd_en2_n = 1;
    settle();
    chk("R5 one enable data", int'(qbus), 0);
    chk("R5 one enable empty_n", empty_n, 1);
    // R8 oe toggling does not move pointers
    repeat (4) begin
      @(negedge rd_clk); oe_n = ~oe_n;
    end
    oe_n = 0;
    settle();
    chk("R8 oe no move", empty_n, 1);
    pop();
    chk("R9 single word", int'(qbus), 9'h0A5);
    settle();
    chk("R9 hold", int'(qbus), 9'h0A5);
    chk("R5 drained", empty_n, 0);
    pop();
    chk("R5 empty read blocked", int'(qbus), 9'h0A5);

    // R6 R7 sweep over offsets and every level
    for (int p = 0; p < 4; p++) begin
      afull_ofs = AW'(xs[p]); aempty_ofs = AW'(ys[p]);
      do_reset(1'b1);
      chk_flags("lvl0", 0, xs[p], ys[p]);
      for (int i = 0; i < D; i++) begin
        push(pat(p, i));
        settle();
        chk_flags("fill", i + 1, xs[p], ys[p]);
      end
      push(9'h1AB);
      settle();
      chk_flags("R4 overflow", D, xs[p], ys[p]);
      for (int i = 0; i < D; i++) begin
        pop();
        chk("R9 order", int'(qbus), int'(pat(p, i)));
        settle();
        chk_flags("drain", D - 1 - i, xs[p], ys[p]);
      end
      chk("R4 discarded word absent", empty_n, 0);
    end

    // R1 reset in mid-run
    push(9'h033); push(9'h044); settle();
    pop();
    chk("R1 pre data", int'(qbus), 9'h033);
    @(negedge wr_clk); rst_n = 0; #1;
    chk("R1 mid full_n", full_n, 1);
    chk("R1 mid empty_n", empty_n, 0);
    chk("R1 mid aempty_n", aempty_n, 0);
    chk("R1 mid data", int'(qbus), 0);
    repeat (2) @(negedge wr_clk);
    rst_n = 1;
    settle();
    chk("R1 post empty_n", empty_n, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule